// File: doc/BRIEF.md
# Peripheral Request to Channel Mapper

This block sits between a set of peripheral DMA request lines and a bank of DMA channels. Software decides, one request line at a time, which channel that line feeds. It does this by writing a small mapping entry that holds a valid flag and a channel number. Every cycle the mapper forwards each mapped request to its chosen channel. When several lines point at the same channel, their requests are combined.

The mapper also gathers the channels' completion and error events. Each channel has a status word whose bits stay set until software writes ones to clear them. A read-only summary word shows which channels have anything pending, and a single interrupt output is raised whenever any summary bit is set. A per-channel alignment word tells each channel whether it may work on byte-aligned addresses.

All registers are reached through a simple word-aligned register port. Writes take effect at the next clock edge. Read data appears one cycle after the read strobe.

Top module: `dreq_chan_mapper`

## Requirements
- R1: After synchronous reset, the following all read as zero: every mapping entry, every channel status word, the alignment word and the summary word. `ch_req`, `ch_byte_align`, `irq` and `reg_rdata` are also zero.
- R2: A mapping entry word uses bit 7 as the valid flag and bits 4:0 as the channel number. On readback, every other bit is zero whatever was written to it.
- R3: If request line r has a valid entry naming channel c (with c below NUM_CH), `ch_req[c]` equals `periph_req[r]` one clock later. Without any request input, no channel request is raised.
- R4: When several valid entries name the same channel, that channel's request is the OR of their request lines.
- R5: Writing zero to a mapping entry unmaps its line. The line's request then reaches no channel.
- R6: The entry for line r is at byte address 0x400 + 4·r when r is below 64, and at 0x800 + 4·(r−64) otherwise. Entries for lines at or above NUM_REQ ignore writes and read as zero. Accesses whose two low address bits are not zero are ignored.
- R7: The status word of channel c is at byte address 4·c. A `ch_done[c]` pulse sets bit 0 and a `ch_err[c]` pulse sets bit 1. Both bits stay set until a write with a one in that bit position clears them. If a set and a clear land in the same cycle, the set wins.
- R8: The summary word at 0x0C0 has bit c set while channel c's status word is non-zero. The bit drops on the cycle after the status bits clear. Writes to the summary word have no effect.
- R9: The alignment word at 0x080 holds one bit per channel. It is written whole, and bit c drives `ch_byte_align[c]` from the next cycle on.
- R10: `irq` is the OR of all summary bits, registered. It rises two cycles after the event pulse that sets a status bit.
- R11: `reg_rdata` carries the addressed word one cycle after `reg_rd` and is zero otherwise. Unused addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 16 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_rd |
| periph_req | input | NUM_REQ | Peripheral request lines |
| ch_req | output | NUM_CH | Routed request, one per channel |
| ch_done | input | NUM_CH | Per-channel completion event pulse |
| ch_err | input | NUM_CH | Per-channel error event pulse |
| ch_byte_align | output | NUM_CH | Per-channel byte-alignment enable |
| irq | output | 1 | Combined interrupt |

## Verification
Suppose a mapping entry holds a wrong valid bit or channel number. The fault shows at `ch_req` one cycle after the affected line is driven: the request either lands on the wrong channel or vanishes, and it also reads back wrong on the next register read. Suppose a status bit latches or clears at the wrong time. The summary readback is then wrong on the following cycle and `irq` one cycle after that, so a set-versus-clear collision is visible within two cycles. Bank decoding errors appear when an entry written through one bank reads back, or routes, as a line of the other bank.

// File: rtl/dreq_map_pkg.sv
package dreq_map_pkg;
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 16;
  localparam int MAP_CH_W    = 5;
  localparam int MAP_VLD_BIT = 7;
  localparam int BANK_SPAN   = 64;
  localparam int MAP_IDX_W   = $clog2(BANK_SPAN) + 1;
  localparam int MAX_CH      = 1 << MAP_CH_W;

  localparam logic [ADDR_W-1:0] ALIGN_ADDR = 16'h0080;
  localparam logic [ADDR_W-1:0] SUM_ADDR   = 16'h00C0;
  localparam logic [ADDR_W-1:0] BANK0_BASE = 16'h0400;
  localparam logic [ADDR_W-1:0] BANK1_BASE = 16'h0800;

  typedef struct packed {
    logic                valid;
    logic [MAP_CH_W-1:0] chan;
  } map_entry_t;

  function automatic logic [DATA_W-1:0] entry_to_word(map_entry_t e);
    logic [DATA_W-1:0] w;
    w = '0;
    w[MAP_VLD_BIT]    = e.valid;
    w[MAP_CH_W-1:0]   = e.chan;
    return w;
  endfunction

  function automatic map_entry_t word_to_entry(logic [DATA_W-1:0] w);
    map_entry_t e;
    e.valid = w[MAP_VLD_BIT];
    e.chan  = w[MAP_CH_W-1:0];
    return e;
  endfunction
endpackage

// File: rtl/dreq_map_table.sv
module dreq_map_table
  import dreq_map_pkg::*;
#(
  parameter int NUM_REQ = 80,
  localparam int IDX_W  = $clog2(NUM_REQ)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  map_entry_t               wr_entry,
  output map_entry_t [NUM_REQ-1:0] entries
);
  // One flop set per request line: routing needs every entry at once.
  for (genvar r = 0; r < NUM_REQ; r++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        entries[r] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(r))) begin
        entries[r] <= wr_entry;
      end
    end
  end
endmodule

// File: rtl/dreq_router.sv
module dreq_router
  import dreq_map_pkg::*;
#(
  parameter int NUM_REQ = 80,
  parameter int NUM_CH  = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  map_entry_t [NUM_REQ-1:0] entries,
  input  logic [NUM_REQ-1:0]       periph_req,
  output logic [NUM_CH-1:0]        ch_req
);
  logic [NUM_CH-1:0] hit_vec;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_comb begin
      hit_vec[c] = 1'b0;
      for (int r = 0; r < NUM_REQ; r++) begin
        if (entries[r].valid && (entries[r].chan == MAP_CH_W'(c)) && periph_req[r])
          hit_vec[c] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ch_req <= '0;
    else     ch_req <= hit_vec;
  end
endmodule

// File: rtl/dreq_irq_status.sv
module dreq_irq_status #(
  parameter int NUM_CH = 32,
  localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CH-1:0]   ch_done,
  input  logic [NUM_CH-1:0]   ch_err,
  input  logic                clr_en,
  input  logic [CH_IDX_W-1:0] clr_idx,
  input  logic [1:0]          clr_bits,
  output logic [NUM_CH-1:0]   done_q,
  output logic [NUM_CH-1:0]   err_q,
  output logic [NUM_CH-1:0]   pend_vec,
  output logic                irq
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_st
    logic sel;
    assign sel = clr_en && (clr_idx == CH_IDX_W'(c));
    always_ff @(posedge clk) begin
      if (rst) begin
        done_q[c] <= 1'b0;
        err_q[c]  <= 1'b0;
      end else begin
        // a new event in the same cycle beats the clear
        done_q[c] <= ch_done[c] | (done_q[c] & ~(sel & clr_bits[0]));
        err_q[c]  <= ch_err[c]  | (err_q[c]  & ~(sel & clr_bits[1]));
      end
    end
  end

  assign pend_vec = done_q | err_q;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |pend_vec;
  end
endmodule

// File: rtl/dreq_chan_mapper.sv
module dreq_chan_mapper
  import dreq_map_pkg::*;
#(
  parameter int NUM_REQ = 80,
  parameter int NUM_CH  = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [15:0]         reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_REQ-1:0]  periph_req,
  output logic [NUM_CH-1:0]   ch_req,
  input  logic [NUM_CH-1:0]   ch_done,
  input  logic [NUM_CH-1:0]   ch_err,
  output logic [NUM_CH-1:0]   ch_byte_align,
  output logic                irq
);
  localparam int IDX_W    = $clog2(NUM_REQ);
  localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  // ---------------- address decode ----------------
  logic                 aligned;
  logic                 in_bank0, in_bank1, map_ok;
  logic [MAP_IDX_W-1:0] map_idx;
  logic                 st_ok, align_hit, sum_hit;
  logic [MAP_CH_W-1:0]  st_ch;

  assign aligned   = (reg_addr[1:0] == 2'b00);
  assign in_bank0  = aligned && (reg_addr[15:8] == BANK0_BASE[15:8]);
  assign in_bank1  = aligned && (reg_addr[15:8] == BANK1_BASE[15:8]);
  assign map_idx   = {in_bank1, reg_addr[7:2]};
  assign map_ok    = (in_bank0 || in_bank1) && (int'(map_idx) < NUM_REQ);
  assign st_ch     = reg_addr[6:2];
  assign st_ok     = aligned && (reg_addr[15:7] == '0) && (int'(st_ch) < NUM_CH);
  assign align_hit = aligned && (reg_addr == ALIGN_ADDR);
  assign sum_hit   = aligned && (reg_addr == SUM_ADDR);

  // ---------------- mapping table ----------------
  map_entry_t [NUM_REQ-1:0] entries;

  dreq_map_table #(.NUM_REQ(NUM_REQ)) u_table (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr && map_ok),
    .wr_idx   (IDX_W'(map_idx)),
    .wr_entry (word_to_entry(reg_wdata)),
    .entries  (entries)
  );

  // ---------------- routing ----------------
  dreq_router #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_router (
    .clk        (clk),
    .rst        (rst),
    .entries    (entries),
    .periph_req (periph_req),
    .ch_req     (ch_req)
  );

  // ---------------- status and summary ----------------
  logic [NUM_CH-1:0] done_q, err_q, pend_vec;

  dreq_irq_status #(.NUM_CH(NUM_CH)) u_status (
    .clk      (clk),
    .rst      (rst),
    .ch_done  (ch_done),
    .ch_err   (ch_err),
    .clr_en   (reg_wr && st_ok),
    .clr_idx  (CH_IDX_W'(st_ch)),
    .clr_bits (reg_wdata[1:0]),
    .done_q   (done_q),
    .err_q    (err_q),
    .pend_vec (pend_vec),
    .irq      (irq)
  );

  // ---------------- alignment word ----------------
  always_ff @(posedge clk) begin
    if (rst)                       ch_byte_align <= '0;
    else if (reg_wr && align_hit)  ch_byte_align <= reg_wdata[NUM_CH-1:0];
  end

  // ---------------- read path ----------------
  logic [31:0] sum_word, align_word, st_word, map_word;

  always_comb begin
    sum_word   = '0;
    align_word = '0;
    st_word    = '0;
    map_word   = '0;
    sum_word[NUM_CH-1:0]   = pend_vec;
    align_word[NUM_CH-1:0] = ch_byte_align;
    if (st_ok) st_word[1:0] = {err_q[CH_IDX_W'(st_ch)], done_q[CH_IDX_W'(st_ch)]};
    if (map_ok) map_word = entry_to_word(entries[IDX_W'(map_idx)]);
  end

  always_ff @(posedge clk) begin
    if (rst || !reg_rd)  reg_rdata <= '0;
    else if (map_ok)     reg_rdata <= map_word;
    else if (st_ok)      reg_rdata <= st_word;
    else if (align_hit)  reg_rdata <= align_word;
    else if (sum_hit)    reg_rdata <= sum_word;
    else                 reg_rdata <= '0;
  end
endmodule

// File: rtl/dreq_chan_mapper_chk.sv
module dreq_chan_mapper_chk #(
  parameter int NUM_REQ = 80,
  parameter int NUM_CH  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [31:0]        reg_rdata,
  input logic [NUM_REQ-1:0] periph_req,
  input logic [NUM_CH-1:0]  ch_req,
  input logic [NUM_CH-1:0]  ch_done,
  input logic [NUM_CH-1:0]  ch_err,
  input logic [NUM_CH-1:0]  ch_byte_align,
  input logic [NUM_CH-1:0]  pend_vec,
  input logic               irq
);
  // R1
  rst_clears_out_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ch_req == '0 && irq == 1'b0 && ch_byte_align == '0));

  // R3
  idle_req_chk: assert property (@(posedge clk) disable iff (rst)
    (periph_req == '0) |=> (ch_req == '0));

  // R10
  pend_raises_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (|(ch_done | ch_err)) |-> ##2 irq);

  // R8
  clear_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_vec == '0) |=> !irq);

  // R9
  align_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> $stable(ch_byte_align));

  // R11
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> (reg_rdata == '0));
endmodule

bind dreq_chan_mapper dreq_chan_mapper_chk #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .reg_wr        (reg_wr),
  .reg_rd        (reg_rd),
  .reg_rdata     (reg_rdata),
  .periph_req    (periph_req),
  .ch_req        (ch_req),
  .ch_done       (ch_done),
  .ch_err        (ch_err),
  .ch_byte_align (ch_byte_align),
  .pend_vec      (pend_vec),
  .irq           (irq)
);

// File: tb/dreq_chan_mapper_bench.sv
module dreq_chan_mapper_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NREQ = 80;
  localparam int NCH  = 32;
  localparam int SEL_RD = 0, SEL_REQ = 1, SEL_IRQ = 2, SEL_ALN = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0]     reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [NREQ-1:0] periph_req = '0;
  logic [NCH-1:0]  ch_req, ch_byte_align;
  logic [NCH-1:0]  ch_done = '0, ch_err = '0;
  logic            irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  dreq_chan_mapper #(.NUM_REQ(NREQ), .NUM_CH(NCH)) u_dreq_chan_mapper (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
    .ch_req(ch_req), .ch_done(ch_done), .ch_err(ch_err),
    .ch_byte_align(ch_byte_align), .irq(irq)
  );

  typedef struct {
    int          due;
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    n_cmp = 0, n_bad = 0;
  bit    done_flag = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare results as they become due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.sel)
        SEL_RD:  act = reg_rdata;
        SEL_REQ: act = ch_req;
        SEL_IRQ: act = {31'b0, irq};
        default: act = ch_byte_align;
      endcase
      n_cmp++;
      if (it.due != cyc || act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual 0x%08h expected 0x%08h (due %0d at %0d)",
                 it.tag, act, it.exp, it.due, cyc);
      end
    end
  end

  function automatic logic [15:0] map_addr(int r);
    if (r < 64) return 16'h0400 + 16'(4 * r);
    return 16'h0800 + 16'(4 * (r - 64));
  endfunction

  task automatic push(int sel, logic [31:0] exp, string tag);
    item_t it;
    it.due = cyc + 1; it.sel = sel; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, logic [31:0] exp, string tag);
    push(SEL_RD, exp, tag);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic drive_req(logic [NREQ-1:0] v, logic [31:0] exp, string tag);
    periph_req = v;
    push(SEL_REQ, exp, tag);
    @(negedge clk);
  endtask

  task automatic pulse(logic [NCH-1:0] d, logic [NCH-1:0] e);
    ch_done = d; ch_err = e;
    @(negedge clk);
    ch_done = '0; ch_err = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    push(SEL_REQ, 32'h0, "R1 ch_req");
    push(SEL_IRQ, 32'h0, "R1 irq");
    push(SEL_ALN, 32'h0, "R1 align");
    @(negedge clk);
    rd(map_addr(0), 32'h0, "R1 map entry");
    rd(16'h0000, 32'h0, "R1 status word");
    rd(16'h00C0, 32'h0, "R1 summary");

    // R2 field format
    wr(map_addr(3), 32'hFFFF_FFE5);
    rd(map_addr(3), 32'h0000_0085, "R2 readback");

    // R3 routing
    drive_req(NREQ'(1) << 3, 32'h1 << 5, "R3 route line3");
    drive_req('0, 32'h0, "R3 release");

    // R6 bank1 entry (line 70), R4 OR
    wr(map_addr(70), 32'h85);
    wr(map_addr(10), 32'h85);
    wr(map_addr(11), 32'h89);
    rd(16'h0818, 32'h85, "R6 bank1 readback");
    rd(16'h0418, 32'h0, "R6 bank0 line6 untouched");
    drive_req(NREQ'(1) << 70, 32'h1 << 5, "R6 route line70");
    drive_req((NREQ'(1) << 70) | (NREQ'(1) << 10), 32'h1 << 5, "R4 merge same channel");
    drive_req((NREQ'(1) << 3) | (NREQ'(1) << 11), (32'h1 << 5) | (32'h1 << 9), "R4 two channels");
    drive_req('0, 32'h0, "R3 release2");

    // R6 out-of-range line and misaligned access
    wr(16'h0850, 32'h85);
    rd(16'h0850, 32'h0, "R6 beyond NUM_REQ");
    wr(16'h0401, 32'h0);
    rd(map_addr(0), 32'h0, "R6 misaligned ignored");
    rd(map_addr(3), 32'h85, "R6 misaligned kept line3");

    // R5 unmap
    wr(map_addr(3), 32'h0);
    drive_req(NREQ'(1) << 3, 32'h0, "R5 unmapped line");
    drive_req('0, 32'h0, "R5 release");

    // R9 alignment
    wr(16'h0080, 32'hA5A5_0001);
    push(SEL_ALN, 32'hA5A5_0001, "R9 align output");
    rd(16'h0080, 32'hA5A5_0001, "R9 align readback");

    // R7 status, R10 irq
    pulse(32'h1 << 4, '0);
    push(SEL_IRQ, 32'h1, "R10 irq rise");
    rd(16'h0010, 32'h1, "R7 done bit");
    pulse('0, 32'h1 << 4);
    rd(16'h0010, 32'h3, "R7 err bit");
    rd(16'h00C0, 32'h1 << 4, "R8 summary set");
    wr(16'h0010, 32'h1);
    rd(16'h0010, 32'h2, "R7 w1c done");
    ch_done = 32'h1 << 4;
    wr(16'h0010, 32'h1);
    ch_done = '0;
    rd(16'h0010, 32'h3, "R7 set beats clear");

    // R8 summary ignores writes, then clears
    wr(16'h00C0, 32'hFFFF_FFFF);
    rd(16'h00C0, 32'h1 << 4, "R8 write ignored");
    wr(16'h0010, 32'h3);
    push(SEL_IRQ, 32'h0, "R10 irq drop");
    rd(16'h00C0, 32'h0, "R8 summary cleared");

    // R11 unused address
    rd(16'h00C4, 32'h0, "R11 unused address");
    repeat (3) @(negedge clk);
    done_flag = 1'b1;
  end

  initial begin : finisher
    for (int i = 0; i < 5000 && !done_flag; i++) @(posedge clk);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: actual %0d items left expected 0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule